// File: doc/BRIEF.md
# Split-Timeout Control Register File

This block is a small control-register file for a node on a serial bus. It holds a node state word with two write addresses, one that sets bits and one that clears them, plus a pair of split-timeout registers. The high register keeps a count of whole seconds. The low register keeps the fraction of a second, in 125 µs bus cycles, in its top 13 bits.

A write to the fraction register is forced into the legal window of 800 to 7999 cycles, so a timeout shorter than 100 ms or longer than one second is never stored. The two registers combine into one registered count of bus cycles, seconds × 8000 + fraction, which drives a transaction timer. A down-counter is included as that timer. A start pulse loads it with the combined count, each cycle-tick input decrements it, and an expired flag rises when it reaches zero.

Software reaches the block through a plain 32-bit address and strobe bus. Because the seconds and the fraction are written separately, the combined count may for a time show a new seconds value paired with the old fraction.

Top module: `split_timeout_csr`

## Requirements
- R1: After reset the state word is 0, the seconds register is 0, the fraction register reads 800<<19 (0x19000000) and the combined timeout output is 800.
- R2: A write to byte offset 0x004 ORs the write data into the state word.
- R3: A write to byte offset 0x000 clears each state bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x018 keeps only write-data bits 2:0 as whole seconds. Bits 31:3 of that register read as zero.
- R5: A write to offset 0x01C whose fraction field, bits 31:19, is below 800 stores 800.
- R6: A write to offset 0x01C whose fraction field is above 7999 stores 7999. A fraction from 800 to 7999 is stored unchanged. Bits 18:0 of that register read as zero and ignore writes.
- R7: The timeout output equals seconds × 8000 + fraction. It changes at the second rising edge after the edge that samples the write.
- R8: With rdEn high, reads at 0x000 and 0x004 both return the state word, and any other unmapped offset returns 0. With rdEn low, rdData is 0. Writes to unmapped offsets change nothing.
- R9: After a write to the seconds register alone, the timeout output combines the new seconds with the fraction that was already stored.
- R10: A timerStart pulse loads the timer with the current timeout output. Each cycleTick then decrements the timer, and timerExpired rises once the timer reaches zero. When timerStart and cycleTick fall in the same cycle, the load wins and no decrement takes place.
- R11: timerExpired stays high, and further cycleTick pulses have no effect, until the next timerStart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 12 | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from addr and rdEn |
| timeoutCycles | output | 16 | Combined split timeout in bus cycles |
| timerStart | input | 1 | Loads the timer from timeoutCycles |
| cycleTick | input | 1 | One pulse per bus cycle, decrements the timer |
| timerExpired | output | 1 | Timer has counted down to zero |

## Verification
The timer can receive a load and a decrement in the same cycle. To provoke this, the bench raises timerStart and cycleTick together. It then counts the ticks needed to reach expiry, and exactly the full timeout must be required, which shows the tick was discarded. A second collision puts a fraction write in the same cycle as timerStart. The timer must load the old combined count, because the new one only appears two edges later, and this is judged by the number of ticks to expiry. The half-written timeout state is judged from the table by reading timeoutCycles after a seconds-only write.

// File: rtl/stcsr_pkg.sv
package stcsr_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_STATE = 2'd1,
    SEL_SEC   = 2'd2,
    SEL_FRAC  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   stateSet;
    logic   stateClr;
    logic   secWr;
    logic   fracWr;
    rdSel_e rdSel;
  } csrStrobe_t;

endpackage

// File: rtl/stcsr_ctrl.sv
module stcsr_ctrl
  import stcsr_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int OFF_CLR  = 'h000,
  parameter int OFF_SET  = 'h004,
  parameter int OFF_SEC  = 'h018,
  parameter int OFF_FRAC = 'h01C
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output csrStrobe_t        strb
);

  logic hitClr, hitSet, hitSec, hitFrac;

  always_comb begin
    hitClr  = (addr == ADDR_W'(OFF_CLR));
    hitSet  = (addr == ADDR_W'(OFF_SET));
    hitSec  = (addr == ADDR_W'(OFF_SEC));
    hitFrac = (addr == ADDR_W'(OFF_FRAC));

    strb.stateClr = wrEn & hitClr;
    strb.stateSet = wrEn & hitSet;
    strb.secWr    = wrEn & hitSec;
    strb.fracWr   = wrEn & hitFrac;

    if (!rdEn)                 strb.rdSel = SEL_NONE;
    else if (hitClr || hitSet) strb.rdSel = SEL_STATE;
    else if (hitSec)           strb.rdSel = SEL_SEC;
    else if (hitFrac)          strb.rdSel = SEL_FRAC;
    else                       strb.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/stcsr_dpath.sv
module stcsr_dpath
  import stcsr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SEC_W       = 3,
  parameter int FRAC_W      = 13,
  parameter int FRAC_LSB    = 19,
  parameter int FRAC_MIN    = 800,
  parameter int FRAC_MAX    = 7999,
  parameter int CYC_PER_SEC = 8000,
  parameter int TO_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [TO_W-1:0]   timeoutCycles
);

  logic [DATA_W-1:0] stateReg;
  logic [SEC_W-1:0]  secReg;
  logic [FRAC_W-1:0] fracReg;
  logic [FRAC_W-1:0] wrFrac;
  logic [FRAC_W-1:0] fracClamped;
  logic [TO_W-1:0]   timeoutNext;

  // Saturate the incoming fraction field into the legal window.
  always_comb begin
    wrFrac = wrData[FRAC_LSB +: FRAC_W];
    if (wrFrac < FRAC_W'(FRAC_MIN))      fracClamped = FRAC_W'(FRAC_MIN);
    else if (wrFrac > FRAC_W'(FRAC_MAX)) fracClamped = FRAC_W'(FRAC_MAX);
    else                                 fracClamped = wrFrac;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateReg <= '0;
      secReg   <= '0;
      fracReg  <= FRAC_W'(FRAC_MIN);
    end else begin
      if (strb.stateSet)      stateReg <= stateReg | wrData;
      else if (strb.stateClr) stateReg <= stateReg & ~wrData;
      if (strb.secWr)  secReg  <= wrData[SEC_W-1:0];
      if (strb.fracWr) fracReg <= fracClamped;
    end
  end

  assign timeoutNext = TO_W'(secReg) * TO_W'(CYC_PER_SEC) + TO_W'(fracReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timeoutCycles <= TO_W'(FRAC_MIN);
    else       timeoutCycles <= timeoutNext;
  end

  always_comb begin
    case (strb.rdSel)
      SEL_STATE: rdData = stateReg;
      SEL_SEC:   rdData = DATA_W'(secReg);
      SEL_FRAC:  rdData = DATA_W'({fracReg, {FRAC_LSB{1'b0}}});
      default:   rdData = '0;
    endcase
  end

  // R2: bits written at the set address are all present afterwards
  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rstN)
    strb.stateSet |=> ((stateReg & $past(wrData)) == $past(wrData)));

  // R3: bits written at the clear address are all gone afterwards
  a_r3_clr_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stateClr && !strb.stateSet) |=> ((stateReg & $past(wrData)) == '0));

  // R5 / R6: the stored fraction never leaves the legal window
  a_r6_frac_window: assert property (@(posedge clk) disable iff (!rstN)
    (fracReg >= FRAC_W'(FRAC_MIN)) && (fracReg <= FRAC_W'(FRAC_MAX)));

  // R7: with no register write the combined timeout stays put
  a_r7_to_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.secWr && !strb.fracWr && (timeoutCycles == timeoutNext))
      |=> $stable(timeoutCycles));

endmodule

// File: rtl/stcsr_timer.sv
module stcsr_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            timerStart,
  input  logic            cycleTick,
  input  logic [TO_W-1:0] loadValue,
  output logic            timerExpired
);

  logic [TO_W-1:0] countReg;
  logic            armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg <= '0;
      armed    <= 1'b0;
    end else if (timerStart) begin
      countReg <= loadValue;
      armed    <= 1'b1;
    end else if (cycleTick && armed && (countReg != '0)) begin
      countReg <= countReg - 1'b1;
    end
  end

  assign timerExpired = armed && (countReg == '0);

  // R10: a start loads the presented timeout, even alongside a tick
  a_r10_load: assert property (@(posedge clk) disable iff (!rstN)
    timerStart |=> (countReg == $past(loadValue)));

  // R10: a tick on a running timer takes exactly one off
  a_r10_dec: assert property (@(posedge clk) disable iff (!rstN)
    (!timerStart && cycleTick && armed && (countReg != '0))
      |=> (countReg == $past(countReg) - 1'b1));

  // R11: expiry holds until the next start
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (timerExpired && !timerStart) |=> timerExpired);

endmodule

// File: rtl/split_timeout_csr.sv
module split_timeout_csr
  import stcsr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int SEC_W       = 3,
  parameter int FRAC_W      = 13,
  parameter int FRAC_MIN    = 800,
  parameter int FRAC_MAX    = 7999,
  parameter int CYC_PER_SEC = 8000,
  localparam int FRAC_LSB   = DATA_W - FRAC_W,
  localparam int TO_W       = $clog2(((1 << SEC_W) - 1) * CYC_PER_SEC + FRAC_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [TO_W-1:0]   timeoutCycles,
  input  logic              timerStart,
  input  logic              cycleTick,
  output logic              timerExpired
);

  csrStrobe_t strb;

  stcsr_ctrl #(
    .ADDR_W(ADDR_W)
  ) uCtrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  stcsr_dpath #(
    .DATA_W      (DATA_W),
    .SEC_W       (SEC_W),
    .FRAC_W      (FRAC_W),
    .FRAC_LSB    (FRAC_LSB),
    .FRAC_MIN    (FRAC_MIN),
    .FRAC_MAX    (FRAC_MAX),
    .CYC_PER_SEC (CYC_PER_SEC),
    .TO_W        (TO_W)
  ) uDpath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .wrData        (wrData),
    .rdData        (rdData),
    .timeoutCycles (timeoutCycles)
  );

  stcsr_timer #(
    .TO_W(TO_W)
  ) uTimer (
    .clk          (clk),
    .rstN         (rstN),
    .timerStart   (timerStart),
    .cycleTick    (cycleTick),
    .loadValue    (timeoutCycles),
    .timerExpired (timerExpired)
  );

endmodule

// File: tb/sim_split_timeout_csr.sv
module sim_split_timeout_csr;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [15:0] timeoutCycles;
  logic        timerStart = 1'b0;
  logic        cycleTick = 1'b0;
  logic        timerExpired;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  split_timeout_csr u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .timeoutCycles(timeoutCycles),
    .timerStart(timerStart), .cycleTick(cycleTick), .timerExpired(timerExpired)
  );

  // tag(32) addr(12) wrData(32) expected read(32) expected timeout(16)
  localparam int NV = 15;
  localparam logic [123:0] VEC [NV] = '{
    {"R2  ", 12'h004, 32'h0000_00A5, 32'h0000_00A5, 16'd800},
    {"R8  ", 12'h004, 32'h0000_0F00, 32'h0000_0FA5, 16'd800},
    {"R3  ", 12'h000, 32'h0000_0081, 32'h0000_0F24, 16'd800},
    {"R6  ", 12'h01C, 32'h1F40_0000, 32'h1F40_0000, 16'd1000},
    {"R6  ", 12'h01C, 32'h1F47_FFFF, 32'h1F40_0000, 16'd1000},
    {"R5  ", 12'h01C, 32'h0028_0000, 32'h1900_0000, 16'd800},
    {"R6  ", 12'h01C, 32'hFA00_0000, 32'hF9F8_0000, 16'd7999},
    {"R6  ", 12'h01C, 32'hFFFF_FFFF, 32'hF9F8_0000, 16'd7999},
    {"R9  ", 12'h018, 32'hFFFF_FFFA, 32'h0000_0002, 16'd23999},
    {"R7  ", 12'h01C, 32'h1900_0000, 32'h1900_0000, 16'd16800},
    {"R4  ", 12'h018, 32'h0000_0007, 32'h0000_0007, 16'd56800},
    {"R5  ", 12'h01C, 32'h18F8_0000, 32'h1900_0000, 16'd56800},
    {"R7  ", 12'h01C, 32'hF9F8_0000, 32'hF9F8_0000, 16'd63999},
    {"R8  ", 12'h010, 32'hFFFF_FFFF, 32'h0000_0000, 16'd63999},
    {"R4  ", 12'h018, 32'h0000_0000, 32'h0000_0000, 16'd7999}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Write at a falling edge; returns at the falling edge after the sampling edge.
  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readAt(input logic [11:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycleTick = 1'b1;
      @(negedge clk);
      cycleTick = 1'b0;
    end
  endtask

  task automatic startPulse(input bit withTick);
    @(negedge clk);
    timerStart = 1'b1; cycleTick = withTick;
    @(negedge clk);
    timerStart = 1'b0; cycleTick = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    readAt(12'h000, rd); check("R1 state", rd, 32'h0);
    readAt(12'h018, rd); check("R1 seconds", rd, 32'h0);
    readAt(12'h01C, rd); check("R1 fraction", rd, 32'h1900_0000);
    check("R1 timeout", 32'(timeoutCycles), 32'd800);
    check("R1 expired", 32'(timerExpired), 32'd0);
    rdEn = 1'b0; addr = 12'h01C; #1;
    check("R8 rdEn low", rdData, 32'h0);

    for (int i = 0; i < NV; i++) begin
      doWrite(VEC[i][91:80], VEC[i][79:48]);
      readAt(VEC[i][91:80], rd);
      check({string'(VEC[i][123:92]), " read"}, rd, VEC[i][47:16]);
      @(negedge clk);
      check({string'(VEC[i][123:92]), " timeout"}, 32'(timeoutCycles), 32'(VEC[i][15:0]));
    end

    readAt(12'h000, rd); check("R8 state after unmapped write", rd, 32'h0000_0F24);
    readAt(12'h004, rd); check("R8 state at set offset", rd, 32'h0000_0F24);

    // Timer: bring timeout to 800
    doWrite(12'h01C, 32'h1900_0000);
    @(negedge clk);
    check("R7 timeout 800", 32'(timeoutCycles), 32'd800);

    startPulse(1'b0);
    check("R10 not expired after load", 32'(timerExpired), 32'd0);
    tick(799);
    check("R10 not expired at 1", 32'(timerExpired), 32'd0);
    tick(1);
    check("R10 expired at 0", 32'(timerExpired), 32'd1);
    tick(3);
    check("R11 expiry held under ticks", 32'(timerExpired), 32'd1);

    // Collision: start and tick together, load wins
    startPulse(1'b1);
    check("R11 start clears expiry", 32'(timerExpired), 32'd0);
    tick(799);
    check("R10 collision tick discarded", 32'(timerExpired), 32'd0);
    tick(1);
    check("R10 collision full count", 32'(timerExpired), 32'd1);

    // Collision: fraction write and start together loads old timeout
    @(negedge clk);
    wrEn = 1'b1; addr = 12'h01C; wrData = 32'h1F40_0000; timerStart = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; timerStart = 1'b0;
    @(negedge clk);
    check("R9 new fraction visible", 32'(timeoutCycles), 32'd1000);
    tick(799);
    check("R10 old count still running", 32'(timerExpired), 32'd0);
    tick(1);
    check("R10 old count expired", 32'(timerExpired), 32'd1);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule